// File: doc/BRIEF.md
# Overlapping Register Window File

This block is a register file whose windowed part is laid out as a ring of overlapping windows, with a separate bank of globals beside it. Each access carries a 5-bit logical register number. The block turns it into a physical index using the current window number. Logical 0–7 always reach the same eight global registers. Logical 8–31 reach the parameter, local and temporary groups of the current window.

A window's temporary group is the same storage as the parameter group of the following window. A caller therefore hands over arguments with no copying. A call strobe moves the current window forward by one and a return strobe moves it back by one, both wrapping modulo the window count.

A second pointer marks the oldest window still held on chip. When a call would reuse a window that still holds live data, the block raises an overflow request. When a return would enter a window that was already spilled, it raises an underflow request. In both cases the block holds its pointers until an external agent signals that the spill or fill is done. The memory transfers themselves happen outside the block.

Top module: `reg_window_file`

## Requirements
- R1: Logical registers 0–7 map to physical 0–7 in every window, so a global written in one window reads back unchanged in any other window.
- R2: For window w and logical address L in 8..31, with k = L−8, the physical index is 8 + 127 − ((16·w + k) mod 128). This puts parameters at L 8–15, locals at 16–23 and temporaries at 24–31, and gives window 0 parameters at physical 135–128.
- R3: The temporaries (logical 24–31) of window w are the same registers as the parameters (logical 8–15) of window (w+1) mod 8. This includes the wrap from window 7 to window 0.
- R4: With no trap pending, a lone call moves cwpOut to (cwp+1) mod 8 on the next cycle and a lone return moves it to (cwp−1) mod 8, unless the call or return traps.
- R5: A lone call with no trap pending, when (cwp+2) mod 8 equals swpOut, raises ovfTrap on the next cycle. Both pointers then hold until a cycle with spillDone high. On the following cycle ovfTrap drops and both pointers have advanced by one.
- R6: A lone return with no trap pending, when cwp equals swpOut, raises unfTrap on the next cycle. Both pointers then hold until a cycle with fillDone high. On the following cycle unfTrap drops and both pointers have moved back by one.
- R7: Call and return asserted together are ignored. A call or return arriving while a trap is pending is ignored. A spillDone or fillDone arriving while no matching trap is pending is ignored.
- R8: When a write and a read in the same cycle name the same logical register, the read port returns the write data in that cycle.
- R9: After reset, cwpOut and swpOut are 0, neither trap is raised, and every register reads 0.
- R10: The two read ports are combinational and independent. A write lands at the register selected through the current window and is visible on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| callReq | input | 1 | Call strobe, one cycle |
| retReq | input | 1 | Return strobe, one cycle |
| spillDone | input | 1 | Pulse: oldest window has been saved |
| fillDone | input | 1 | Pulse: previous window has been restored |
| rdAddrA | input | 5 | Logical address, read port A |
| rdDataA | output | 32 | Read data, port A |
| rdAddrB | input | 5 | Logical address, read port B |
| rdDataB | output | 32 | Read data, port B |
| wrEn | input | 1 | Write enable |
| wrAddr | input | 5 | Logical write address |
| wrData | input | 32 | Write data |
| cwpOut | output | 3 | Current window pointer |
| swpOut | output | 3 | Saved window pointer (oldest resident window) |
| ovfTrap | output | 1 | Overflow request, high while a spill is awaited |
| unfTrap | output | 1 | Underflow request, high while a fill is awaited |

## Verification
Two situations are hard to reach from the ports. The first is the wrap of the ring, where window 7's temporaries alias window 0's parameters. The second is a trap that fires only after the pointers have walked around the ring several times with spills and fills interleaved. Directed sequences walk the pointer through six calls into an overflow and then back down into an underflow. A long random phase then biases calls over returns and answers each trap after a random delay. This drives the pointers repeatedly across the wrap while data written through one window is read back through neighbouring windows.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int WIN_IDX_MAX = 8;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wrfState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [WIN_IDX_MAX-1:0] win;
  } wrfCtl_t;
endpackage

// File: rtl/wrf_map.sv
module wrf_map #(
  parameter int NUM_GLOBAL = 8,
  parameter int GRP_SIZE   = 8,
  parameter int NUM_WIN    = 8,
  parameter int LOG_W      = 5,
  parameter int PHYS_W     = 8
) (
  input  logic [LOG_W-1:0]                logAddr,
  input  logic [wrf_pkg::WIN_IDX_MAX-1:0] win,
  output logic [PHYS_W-1:0]               physAddr
);
  localparam int RING = NUM_WIN * 2 * GRP_SIZE;

  int offs;
  int pos;

  always_comb begin
    offs = int'(logAddr) - NUM_GLOBAL;
    pos  = (2 * GRP_SIZE * int'(win) + offs) % RING;
    if (int'(logAddr) < NUM_GLOBAL) begin
      physAddr = PHYS_W'(logAddr);
    end else begin
      physAddr = PHYS_W'(NUM_GLOBAL + RING - 1 - pos);
    end
  end
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             callReq,
  input  logic             retReq,
  input  logic             spillDone,
  input  logic             fillDone,
  output wrf_pkg::wrfCtl_t ctl,
  output logic [WIN_W-1:0] cwp,
  output logic [WIN_W-1:0] swp,
  output logic             ovfTrap,
  output logic             unfTrap
);
  import wrf_pkg::*;

  wrfState_e state;
  logic [WIN_W-1:0] cwpNext, cwpPrev, swpNext, swpPrev;
  logic full, empty, doCall, doRet;

  function automatic logic [WIN_W-1:0] fwd(logic [WIN_W-1:0] w);
    return (int'(w) == NUM_WIN - 1) ? '0 : w + WIN_W'(1);
  endfunction

  function automatic logic [WIN_W-1:0] bwd(logic [WIN_W-1:0] w);
    return (w == '0) ? WIN_W'(NUM_WIN - 1) : w - WIN_W'(1);
  endfunction

  always_comb begin
    cwpNext = fwd(cwp);
    cwpPrev = bwd(cwp);
    swpNext = fwd(swp);
    swpPrev = bwd(swp);
    full    = (fwd(cwpNext) == swp);
    empty   = (cwp == swp);
    doCall  = callReq && !retReq;
    doRet   = retReq && !callReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_RUN;
      cwp   <= '0;
      swp   <= '0;
    end else begin
      case (state)
        ST_RUN: begin
          if (doCall) begin
            if (full) state <= ST_SPILL;
            else      cwp   <= cwpNext;
          end else if (doRet) begin
            if (empty) state <= ST_FILL;
            else       cwp   <= cwpPrev;
          end
        end
        ST_SPILL: begin
          if (spillDone) begin
            cwp   <= cwpNext;
            swp   <= swpNext;
            state <= ST_RUN;
          end
        end
        ST_FILL: begin
          if (fillDone) begin
            cwp   <= cwpPrev;
            swp   <= swpPrev;
            state <= ST_RUN;
          end
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign ovfTrap = (state == ST_SPILL);
  assign unfTrap = (state == ST_FILL);
  assign ctl.win = WIN_IDX_MAX'(cwp);
endmodule

// File: rtl/wrf_data.sv
module wrf_data #(
  parameter int DATA_W     = 32,
  parameter int NUM_GLOBAL = 8,
  parameter int GRP_SIZE   = 8,
  parameter int NUM_WIN    = 8,
  parameter int LOG_W      = 5,
  parameter int NUM_PHYS   = 136,
  parameter int PHYS_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrf_pkg::wrfCtl_t  ctl,
  input  logic [LOG_W-1:0]  rdAddrA,
  input  logic [LOG_W-1:0]  rdAddrB,
  input  logic              wrEn,
  input  logic [LOG_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB
);
  localparam int NUM_PORTS = 3;  // two reads, one write
  localparam int WR_PORT   = NUM_PORTS - 1;

  logic [LOG_W-1:0]  logIn  [NUM_PORTS];
  logic [PHYS_W-1:0] physIx [NUM_PORTS];
  logic [DATA_W-1:0] regs   [NUM_PHYS];

  assign logIn[0]       = rdAddrA;
  assign logIn[1]       = rdAddrB;
  assign logIn[WR_PORT] = wrAddr;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_map
    wrf_map #(
      .NUM_GLOBAL(NUM_GLOBAL),
      .GRP_SIZE  (GRP_SIZE),
      .NUM_WIN   (NUM_WIN),
      .LOG_W     (LOG_W),
      .PHYS_W    (PHYS_W)
    ) u_map (
      .logAddr (logIn[p]),
      .win     (ctl.win),
      .physAddr(physIx[p])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_PHYS; i++) regs[i] <= '0;
    end else if (wrEn) begin
      regs[physIx[WR_PORT]] <= wrData;
    end
  end

  always_comb begin
    rdDataA = (wrEn && physIx[WR_PORT] == physIx[0]) ? wrData : regs[physIx[0]];
    rdDataB = (wrEn && physIx[WR_PORT] == physIx[1]) ? wrData : regs[physIx[1]];
  end
endmodule

// File: rtl/reg_window_file.sv
module reg_window_file #(
  parameter int DATA_W     = 32,
  parameter int NUM_WIN    = 8,
  parameter int GRP_SIZE   = 8,
  parameter int NUM_GLOBAL = 8,
  parameter int LOG_W      = $clog2(NUM_GLOBAL + 3 * GRP_SIZE),
  parameter int WIN_W      = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              callReq,
  input  logic              retReq,
  input  logic              spillDone,
  input  logic              fillDone,
  input  logic [LOG_W-1:0]  rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [LOG_W-1:0]  rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [LOG_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [WIN_W-1:0]  cwpOut,
  output logic [WIN_W-1:0]  swpOut,
  output logic              ovfTrap,
  output logic              unfTrap
);
  localparam int NUM_PHYS = NUM_GLOBAL + NUM_WIN * 2 * GRP_SIZE;
  localparam int PHYS_W   = $clog2(NUM_PHYS);

  wrf_pkg::wrfCtl_t ctl;

  wrf_ctrl #(
    .NUM_WIN(NUM_WIN),
    .WIN_W  (WIN_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .callReq  (callReq),
    .retReq   (retReq),
    .spillDone(spillDone),
    .fillDone (fillDone),
    .ctl      (ctl),
    .cwp      (cwpOut),
    .swp      (swpOut),
    .ovfTrap  (ovfTrap),
    .unfTrap  (unfTrap)
  );

  wrf_data #(
    .DATA_W    (DATA_W),
    .NUM_GLOBAL(NUM_GLOBAL),
    .GRP_SIZE  (GRP_SIZE),
    .NUM_WIN   (NUM_WIN),
    .LOG_W     (LOG_W),
    .NUM_PHYS  (NUM_PHYS),
    .PHYS_W    (PHYS_W)
  ) u_data (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .rdAddrA(rdAddrA),
    .rdAddrB(rdAddrB),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdDataA(rdDataA),
    .rdDataB(rdDataB)
  );
endmodule

// File: rtl/wrf_checker.sv
module wrf_checker #(
  parameter int NUM_WIN = 8,
  parameter int WIN_W   = 3,
  parameter int LOG_W   = 5,
  parameter int DATA_W  = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              callReq,
  input logic              retReq,
  input logic              spillDone,
  input logic              fillDone,
  input logic [LOG_W-1:0]  rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [LOG_W-1:0]  wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic [WIN_W-1:0]  cwpOut,
  input logic [WIN_W-1:0]  swpOut,
  input logic              ovfTrap,
  input logic              unfTrap
);
  function automatic logic [WIN_W-1:0] up1(logic [WIN_W-1:0] w);
    return (int'(w) == NUM_WIN - 1) ? '0 : w + WIN_W'(1);
  endfunction

  function automatic logic [WIN_W-1:0] dn1(logic [WIN_W-1:0] w);
    return (w == '0) ? WIN_W'(NUM_WIN - 1) : w - WIN_W'(1);
  endfunction

  a_r4_call_step: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfTrap && !unfTrap && callReq && !retReq) |=>
      (ovfTrap || cwpOut == up1($past(cwpOut))));

  a_r4_ret_step: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfTrap && !unfTrap && retReq && !callReq) |=>
      (unfTrap || cwpOut == dn1($past(cwpOut))));

  a_r5_spill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && !spillDone) |=> (ovfTrap && $stable(cwpOut) && $stable(swpOut)));

  a_r5_spill_release: assert property (@(posedge clk) disable iff (!rstN)
    (ovfTrap && spillDone) |=>
      (!ovfTrap && cwpOut == up1($past(cwpOut)) && swpOut == up1($past(swpOut))));

  a_r5_one_trap: assert property (@(posedge clk) disable iff (!rstN)
    !(ovfTrap && unfTrap));

  a_r6_fill_hold: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && !fillDone) |=> (unfTrap && $stable(cwpOut) && $stable(swpOut)));

  a_r6_fill_release: assert property (@(posedge clk) disable iff (!rstN)
    (unfTrap && fillDone) |=>
      (!unfTrap && cwpOut == dn1($past(cwpOut)) && swpOut == dn1($past(swpOut))));

  a_r7_both_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfTrap && !unfTrap && callReq && retReq) |=>
      (!ovfTrap && !unfTrap && $stable(cwpOut) && $stable(swpOut)));

  a_r7_swp_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfTrap && !unfTrap) |=> $stable(swpOut));

  a_r8_bypass: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdAddrA == wrAddr) |-> (rdDataA == wrData));
endmodule

bind reg_window_file wrf_checker #(
  .NUM_WIN(NUM_WIN),
  .WIN_W  (WIN_W),
  .LOG_W  (LOG_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .callReq  (callReq),
  .retReq   (retReq),
  .spillDone(spillDone),
  .fillDone (fillDone),
  .rdAddrA  (rdAddrA),
  .rdDataA  (rdDataA),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrData   (wrData),
  .cwpOut   (cwpOut),
  .swpOut   (swpOut),
  .ovfTrap  (ovfTrap),
  .unfTrap  (unfTrap)
);

// File: tb/reg_window_file_tb.sv
module reg_window_file_tb;
  logic        clk;
  logic        rstN;
  logic        callReq, retReq, spillDone, fillDone;
  logic [4:0]  rdAddrA, rdAddrB, wrAddr;
  logic [31:0] rdDataA, rdDataB, wrData;
  logic        wrEn;
  logic [2:0]  cwpOut, swpOut;
  logic        ovfTrap, unfTrap;

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [136];
  int mCwp, mSwp, mState;  // mState: 0 run, 1 awaiting spill, 2 awaiting fill

  reg_window_file u_dut (
    .clk(clk), .rstN(rstN), .callReq(callReq), .retReq(retReq),
    .spillDone(spillDone), .fillDone(fillDone),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cwpOut(cwpOut), .swpOut(swpOut), .ovfTrap(ovfTrap), .unfTrap(unfTrap)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic int mapPhys(int l, int w);
    if (l < 8) return l;
    return 8 + 127 - ((16 * w + (l - 8)) % 128);
  endfunction

  function automatic logic [31:0] expRead(int ra);
    if (wrEn && mapPhys(int'(wrAddr), mCwp) == mapPhys(ra, mCwp)) return wrData;
    return mem[mapPhys(ra, mCwp)];
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    callReq = 0; retReq = 0; spillDone = 0; fillDone = 0; wrEn = 0;
    wrAddr = 0; wrData = 0; rdAddrA = 0; rdAddrB = 0;
  endtask

  // Entered just after a negedge with inputs applied; returns at the next negedge.
  task automatic tick(string tag);
    #2;
    chk(tag, "rdDataA", rdDataA, expRead(int'(rdAddrA)));
    chk(tag, "rdDataB", rdDataB, expRead(int'(rdAddrB)));
    @(posedge clk);
    if (wrEn) mem[mapPhys(int'(wrAddr), mCwp)] = wrData;
    case (mState)
      0: begin
        if (callReq && !retReq) begin
          if ((mCwp + 2) % 8 == mSwp) mState = 1; else mCwp = (mCwp + 1) % 8;
        end else if (retReq && !callReq) begin
          if (mCwp == mSwp) mState = 2; else mCwp = (mCwp + 7) % 8;
        end
      end
      1: if (spillDone) begin mCwp = (mCwp + 1) % 8; mSwp = (mSwp + 1) % 8; mState = 0; end
      default: if (fillDone) begin mCwp = (mCwp + 7) % 8; mSwp = (mSwp + 7) % 8; mState = 0; end
    endcase
    #1;
    chk(tag, "cwpOut", 32'(cwpOut), 32'(mCwp));
    chk(tag, "swpOut", 32'(swpOut), 32'(mSwp));
    chk(tag, "ovfTrap", 32'(ovfTrap), 32'(mState == 1));
    chk(tag, "unfTrap", 32'(unfTrap), 32'(mState == 2));
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd1234));
    idle();
    rstN = 0;
    for (int i = 0; i < 136; i++) mem[i] = '0;
    mCwp = 0; mSwp = 0; mState = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R9: reset state, all storage reads 0
    rdAddrA = 5; rdAddrB = 20; tick("R9");
    rdAddrA = 31; rdAddrB = 8; tick("R9");

    // R1: global stays visible across a call
    wrEn = 1; wrAddr = 3; wrData = 32'h1111_0003; tick("R1");
    callReq = 1; tick("R4");
    rdAddrA = 3; tick("R1");
    chk("R1", "global in window 1", rdDataA, 32'h1111_0003);

    // R3: temporary of window 1 becomes parameter of window 2
    wrEn = 1; wrAddr = 26; wrData = 32'hA5A5_0026; tick("R3");
    callReq = 1; tick("R3");
    rdAddrA = 10; #2; chk("R3", "param after call", rdDataA, 32'hA5A5_0026); #0;
    tick("R3");

    // R2: local of window 2 is not visible as local in window 3
    wrEn = 1; wrAddr = 17; wrData = 32'h0000_B017; tick("R2");
    callReq = 1; tick("R4");
    rdAddrA = 17; rdAddrB = 26; tick("R2");

    // R8: write-first bypass on both ports
    wrEn = 1; wrAddr = 20; wrData = 32'hDEAD_0020; rdAddrA = 20; rdAddrB = 20; tick("R8");
    // R10: independent ports, write visible next cycle
    rdAddrA = 20; rdAddrB = 3; tick("R10");

    // R7: call and return together, and stray done pulses
    callReq = 1; retReq = 1; tick("R7");
    spillDone = 1; tick("R7");
    fillDone = 1; tick("R7");

    // R5: walk to overflow (cwp 3 -> 6, then trap)
    for (int i = 0; i < 3; i++) begin callReq = 1; tick("R4"); end
    callReq = 1; tick("R5");
    tick("R5"); tick("R5");
    callReq = 1; tick("R7");  // ignored while pending
    retReq = 1; tick("R7");
    spillDone = 1; tick("R5");
    chk("R5", "cwp after spill", 32'(cwpOut), 32'd7);
    chk("R5", "swp after spill", 32'(swpOut), 32'd1);

    // R3: wrap from window 7 temporaries into window 0 parameters
    wrEn = 1; wrAddr = 30; wrData = 32'h7777_0030; tick("R3");
    callReq = 1; tick("R5");  // (7+2)%8 == 1 -> trap
    spillDone = 1; tick("R5");
    rdAddrA = 14; tick("R3");
    chk("R3", "wrapped param", rdDataA, 32'h7777_0030);

    // R6: walk down to underflow
    while (!(cwpOut == swpOut)) begin retReq = 1; tick("R4"); end
    retReq = 1; tick("R6");
    tick("R6");
    callReq = 1; tick("R7");
    fillDone = 1; tick("R6");

    // random phase (R2, R4, R5, R6, R8, R10)
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (mState == 0) begin
        if (r < 30) callReq = 1;
        else if (r < 50) retReq = 1;
        else if (r < 53) begin callReq = 1; retReq = 1; end
      end else begin
        if (r < 35) begin spillDone = (mState == 1); fillDone = (mState == 2); end
        else if (r < 45) callReq = 1;
      end
      wrEn    = ($urandom_range(0, 1) == 1);
      wrAddr  = 5'($urandom_range(0, 31));
      wrData  = $urandom;
      rdAddrA = ($urandom_range(0, 3) == 0) ? wrAddr : 5'($urandom_range(0, 31));
      rdAddrB = 5'($urandom_range(0, 31));
      tick("R2");
    end

    summary();
  end
endmodule